// File: doc/BRIEF.md
# DDR2 Burst Read Output Sequencer

This block models the device side of the read path of a DDR2-style memory. On every rising clock edge it decodes the four active-low command inputs. When they form a read, it stores the column on the address bus as the burst's start. The block then counts out the read latency. That latency is the sum of a posted additive latency and a CAS latency, both taken from configuration inputs and clamped to their legal ranges. Next it drives the data strobe low for one full clock as a preamble. Last it plays out a burst of 4 or 8 beats at two beats per clock.

Each clock of the data phase carries two words. The rise word goes out while the strobe is high and the fall word while it is low. A strobe-enable output and a data-valid output frame the transfer. The words come from a small internal array that a load port writes. This lets a test environment place known contents before it issues reads. A read that arrives while an earlier burst still has cycles to run is dropped, and a sticky error flag records it.

Top module: `ddr2_burst_rd`

## Requirements
- R1: A read is recognised only when, at a rising edge, `cmd_sel_n`=0, `cmd_row_n`=1, `cmd_col_n`=0 and `cmd_wr_n`=1; every other combination of those four inputs starts no strobe and no data.
- R2: With a read sampled at edge T0, the first data clock (`dq_valid`=1) begins at edge T0+RL, where RL = AL + CL from `cfg_al` and `cfg_cl`.
- R3: A `cfg_cl` value below 3 acts as 3 and above 6 acts as 6; a `cfg_al` value above 4 acts as 4.
- R4: In the single clock before the first data clock, `dqs_oe`=1, `dqs_hi`=0 and `dq_valid`=0 (preamble).
- R5: `cfg_bl8`=0 gives 4 beats over 2 data clocks and `cfg_bl8`=1 gives 8 beats over 4 data clocks; in each data clock `dqs_oe`=1, `dqs_hi`=1 (strobe high in the first half, low in the second) and `dq_valid`=1.
- R6: In data clock k (from 0), `dq_rise` carries beat 2k and `dq_fall` carries beat 2k+1. Beat j is read from the word whose address keeps the column bits above the burst block and sets the low bits (2 for 4 beats, 3 for 8 beats) to (start low bits + j) modulo the burst length.
- R7: On the clock after the last data clock, `dqs_oe` and `dq_valid` are 0; whenever `dq_valid`=0, `dq_rise` and `dq_fall` are all zeros.
- R8: After a read accepted at edge T0 with latency RL and a burst of n beats over n/2 clocks, a read at an edge before T0+RL+n/2 is ignored and sets `rd_err`. `rd_err` then stays 1 until reset. A read at exactly edge T0+RL+n/2 is accepted.
- R9: Latencies and burst length are taken when the read is accepted; changing the configuration inputs afterwards does not alter that burst.
- R10: While `rst_n`=0 all outputs are 0, and reset clears `rd_err`.
- R11: With `ld_en`=1 at a rising edge, `ld_data` is written to the word at `ld_addr` and is returned by later bursts that read that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_sel_n | input | 1 | Device select, active low |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write enable, active low |
| cmd_addr | input | COL_W | Starting column sampled with a read |
| cfg_cl | input | CFG_W | CAS latency setting |
| cfg_al | input | CFG_W | Additive latency setting |
| cfg_bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | COL_W | Array load address |
| ld_data | input | DQ_W | Array load data |
| dqs_oe | output | 1 | Strobe driven (preamble and data clocks) |
| dqs_hi | output | 1 | Strobe high in the first half of this clock |
| dq_rise | output | DQ_W | Word presented while the strobe is high |
| dq_fall | output | DQ_W | Word presented while the strobe is low |
| dq_valid | output | 1 | Data clock qualifier |
| rd_err | output | 1 | Sticky flag: a read arrived while busy |

## Verification
The bench builds the block with its default parameters: a 4-bit column (16 words), 8-bit words and 3-bit latency fields. Because the fields are only 3 bits wide, the sweep can cover every CAS and additive setting, legal and out of range, with both burst lengths, so each clamp edge and the full latency span of 3 to 10 clocks is exercised. The 16-word array lets the start columns rotate through every alignment inside both the 4-beat and the 8-beat blocks, which exercises each wrap position. A cycle-level model in the bench predicts the strobe, valid and data outputs for every clock, and directed cases cover the exact free edge after a burst, the edge one clock earlier, and the sticky error flag.

// File: rtl/ddr2_burst_rd_pkg.sv
package ddr2_burst_rd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_PRE  = 2'd2,
      PH_DATA = 2'd3
   } rd_phase_e;

   localparam int LANES = 2;

   function automatic int clamp_i(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/ddr2_burst_rd_decode.sv
module ddr2_burst_rd_decode
   import ddr2_burst_rd_pkg::*;
#(
   parameter int CFG_W  = 3,
   parameter int CNT_W  = 5,
   parameter int CL_MIN = 3,
   parameter int CL_MAX = 6,
   parameter int AL_MAX = 4
) (
   input  logic             sel_n,
   input  logic             row_n,
   input  logic             col_n,
   input  logic             wr_n,
   input  logic [CFG_W-1:0] cfg_cl,
   input  logic [CFG_W-1:0] cfg_al,
   output logic             rd_hit,
   output logic [CNT_W-1:0] rl_eff
);

   logic [CNT_W-1:0] cl_eff;
   logic [CNT_W-1:0] al_eff;

   assign rd_hit = !sel_n && row_n && !col_n && wr_n;

   assign cl_eff = CNT_W'(clamp_i(int'(cfg_cl), CL_MIN, CL_MAX));
   assign al_eff = CNT_W'(clamp_i(int'(cfg_al), 0, AL_MAX));
   assign rl_eff = cl_eff + al_eff;

endmodule

// File: rtl/ddr2_burst_rd_timer.sv
module ddr2_burst_rd_timer
   import ddr2_burst_rd_pkg::*;
#(
   parameter int CNT_W = 5,
   parameter int COL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_hit,
   input  logic [CNT_W-1:0] rl_in,
   input  logic             bl8_in,
   input  logic [COL_W-1:0] col_in,
   output rd_phase_e        phase,
   output logic [1:0]       beat_k,
   output logic [COL_W-1:0] col_q,
   output logic             bl8_q,
   output logic             err_q
);

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rl_q;
   logic [1:0]       beat_q;
   logic [CNT_W-1:0] nclk;
   logic [CNT_W-1:0] last_cnt;
   logic             at_last;
   logic             busy;
   logic             accept;

   assign nclk     = bl8_q ? CNT_W'(4) : CNT_W'(2);
   assign last_cnt = rl_q + nclk - CNT_W'(1);
   assign at_last  = active_q && (cnt_q == last_cnt);
   assign busy     = active_q && !at_last;
   assign accept   = rd_hit && !busy;

   always_comb begin
      if (!active_q)                         phase = PH_IDLE;
      else if (cnt_q == rl_q - CNT_W'(1))    phase = PH_PRE;
      else if (cnt_q >= rl_q)                phase = PH_DATA;
      else                                   phase = PH_WAIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         rl_q     <= '0;
         beat_q   <= '0;
         bl8_q    <= 1'b0;
         col_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         if (accept) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            beat_q   <= '0;
            rl_q     <= rl_in;
            bl8_q    <= bl8_in;
            col_q    <= col_in;
         end else if (at_last) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            beat_q   <= '0;
         end else if (active_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (phase == PH_DATA) beat_q <= beat_q + 2'd1;
         end
         if (rd_hit && busy) err_q <= 1'b1;
      end
   end

   assign beat_k = beat_q;

endmodule

// File: rtl/ddr2_burst_rd_addr.sv
module ddr2_burst_rd_addr
   import ddr2_burst_rd_pkg::*;
#(
   parameter int COL_W = 4
) (
   input  logic [COL_W-1:0]            col,
   input  logic                        bl8,
   input  logic [1:0]                  beat_k,
   output logic [LANES-1:0][COL_W-1:0] addr
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [2:0] j;
      logic [2:0] off8;
      logic [1:0] off4;
      assign j    = {beat_k, 1'(g)};
      assign off8 = col[2:0] + j;
      assign off4 = col[1:0] + j[1:0];
      assign addr[g] = bl8 ? {col[COL_W-1:3], off8} : {col[COL_W-1:2], off4};
   end

endmodule

// File: rtl/ddr2_burst_rd_store.sv
module ddr2_burst_rd_store
   import ddr2_burst_rd_pkg::*;
#(
   parameter int COL_W = 4,
   parameter int DQ_W  = 8
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [COL_W-1:0]            wr_addr,
   input  logic [DQ_W-1:0]             wr_data,
   input  logic [LANES-1:0][COL_W-1:0] rd_addr,
   output logic [LANES-1:0][DQ_W-1:0]  rd_data
);

   localparam int DEPTH = 1 << COL_W;

   logic [DQ_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_port
      assign rd_data[g] = mem_q[rd_addr[g]];
   end

endmodule

// File: rtl/ddr2_burst_rd.sv
module ddr2_burst_rd
   import ddr2_burst_rd_pkg::*;
#(
   parameter int COL_W     = 4,
   parameter int DQ_W      = 8,
   parameter int CFG_W     = 3,
   parameter int CL_MIN    = 3,
   parameter int CL_MAX    = 6,
   parameter int AL_MAX    = 4,
   parameter bit QUIET_BUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_sel_n,
   input  logic             cmd_row_n,
   input  logic             cmd_col_n,
   input  logic             cmd_wr_n,
   input  logic [COL_W-1:0] cmd_addr,
   input  logic [CFG_W-1:0] cfg_cl,
   input  logic [CFG_W-1:0] cfg_al,
   input  logic             cfg_bl8,
   input  logic             ld_en,
   input  logic [COL_W-1:0] ld_addr,
   input  logic [DQ_W-1:0]  ld_data,
   output logic             dqs_oe,
   output logic             dqs_hi,
   output logic [DQ_W-1:0]  dq_rise,
   output logic [DQ_W-1:0]  dq_fall,
   output logic             dq_valid,
   output logic             rd_err
);

   localparam int CNT_W = $clog2(CL_MAX + AL_MAX + 4 + 1) + 1;

   if (COL_W < 4) begin : g_bad_col
      $error("COL_W must be at least 4");
   end
   if (CL_MIN < 2 || CL_MAX < CL_MIN) begin : g_bad_cl
      $error("CAS latency range is invalid");
   end
   if (AL_MAX < 0 || ((1 << CFG_W) - 1) < CL_MAX) begin : g_bad_cfg
      $error("configuration field too narrow or AL_MAX negative");
   end

   logic                        rd_hit;
   logic [CNT_W-1:0]            rl_eff;
   rd_phase_e                   phase;
   logic [1:0]                  beat_k;
   logic [COL_W-1:0]            col_q;
   logic                        bl8_q;
   logic [LANES-1:0][COL_W-1:0] rd_addr;
   logic [LANES-1:0][DQ_W-1:0]  rd_word;
   logic                        in_data;

   ddr2_burst_rd_decode #(
      .CFG_W(CFG_W), .CNT_W(CNT_W),
      .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)
   ) u_decode (
      .sel_n (cmd_sel_n),
      .row_n (cmd_row_n),
      .col_n (cmd_col_n),
      .wr_n  (cmd_wr_n),
      .cfg_cl(cfg_cl),
      .cfg_al(cfg_al),
      .rd_hit(rd_hit),
      .rl_eff(rl_eff)
   );

   ddr2_burst_rd_timer #(.CNT_W(CNT_W), .COL_W(COL_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_hit(rd_hit),
      .rl_in (rl_eff),
      .bl8_in(cfg_bl8),
      .col_in(cmd_addr),
      .phase (phase),
      .beat_k(beat_k),
      .col_q (col_q),
      .bl8_q (bl8_q),
      .err_q (rd_err)
   );

   ddr2_burst_rd_addr #(.COL_W(COL_W)) u_addr (
      .col   (col_q),
      .bl8   (bl8_q),
      .beat_k(beat_k),
      .addr  (rd_addr)
   );

   ddr2_burst_rd_store #(.COL_W(COL_W), .DQ_W(DQ_W)) u_store (
      .clk    (clk),
      .wr_en  (ld_en),
      .wr_addr(ld_addr),
      .wr_data(ld_data),
      .rd_addr(rd_addr),
      .rd_data(rd_word)
   );

   assign in_data  = (phase == PH_DATA);
   assign dqs_oe   = (phase == PH_PRE) || in_data;
   assign dqs_hi   = in_data;
   assign dq_valid = in_data;

   if (QUIET_BUS) begin : g_quiet
      assign dq_rise = in_data ? rd_word[0] : '0;
      assign dq_fall = in_data ? rd_word[1] : '0;
   end else begin : g_raw
      assign dq_rise = rd_word[0];
      assign dq_fall = rd_word[1];
   end

endmodule

// File: rtl/ddr2_burst_rd_chk.sv
module ddr2_burst_rd_chk #(
   parameter int DQ_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dqs_oe,
   input logic            dqs_hi,
   input logic            dq_valid,
   input logic            rd_err,
   input logic [DQ_W-1:0] dq_rise,
   input logic [DQ_W-1:0] dq_fall
);

   logic [3:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (dq_valid) run_q <= run_q + 4'd1;
      else               run_q <= '0;
   end

   assert_strobe_on_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dq_valid |-> (dqs_oe && dqs_hi));

   assert_preamble_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dqs_oe) |-> (!dq_valid && !dqs_hi));

   assert_data_after_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_valid) |-> ($past(dqs_oe) && !$past(dq_valid)));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_valid) |-> !dqs_oe);

   assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_valid |-> (dq_rise == '0 && dq_fall == '0));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |=> rd_err);

   assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_valid) |-> (run_q == 4'd2 || run_q == 4'd4));

   assert_no_long_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dq_valid |-> (run_q < 4'd4));

endmodule

bind ddr2_burst_rd ddr2_burst_rd_chk #(.DQ_W(DQ_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dqs_oe  (dqs_oe),
   .dqs_hi  (dqs_hi),
   .dq_valid(dq_valid),
   .rd_err  (rd_err),
   .dq_rise (dq_rise),
   .dq_fall (dq_fall)
);

// File: tb/sim_ddr2_burst_rd.sv
module sim_ddr2_burst_rd;

   localparam int COL_W = 4;
   localparam int DQ_W  = 8;
   localparam int CFG_W = 3;
   localparam int DEPTH = 1 << COL_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_sel_n = 1'b1, cmd_row_n = 1'b1, cmd_col_n = 1'b1, cmd_wr_n = 1'b1;
   logic [COL_W-1:0] cmd_addr = '0;
   logic [CFG_W-1:0] cfg_cl = 3'd3, cfg_al = 3'd0;
   logic cfg_bl8 = 1'b0;
   logic ld_en = 1'b0;
   logic [COL_W-1:0] ld_addr = '0;
   logic [DQ_W-1:0] ld_data = '0;
   logic dqs_oe, dqs_hi, dq_valid, rd_err;
   logic [DQ_W-1:0] dq_rise, dq_fall;

   always #10 clk = ~clk;   // 50 MHz

   ddr2_burst_rd u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_sel_n(cmd_sel_n), .cmd_row_n(cmd_row_n), .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n),
      .cmd_addr(cmd_addr), .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .dqs_oe(dqs_oe), .dqs_hi(dqs_hi), .dq_rise(dq_rise), .dq_fall(dq_fall),
      .dq_valid(dq_valid), .rd_err(rd_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [DQ_W-1:0] shadow [DEPTH];

   // reference model state
   int cyc = 0, t0 = 0, next_free = 0, m_rl = 0, m_n = 0, m_col = 0;
   int lcl = 0, lal = 0, lbl = 0;
   bit have = 1'b0, exp_err = 1'b0, legal = 1'b1;
   // sampling scratch
   int mm, kk;
   bit pre, dat, moved;
   logic [DQ_W-1:0] er, ef;
   string tg;

   function automatic int clampi(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int beat_addr(input int col, input int n, input int j);
      int off;
      off = col % n;
      return col - off + (off + j) % n;
   endfunction

   function automatic int pat(input int a);
      return (a * 37 + 11) % 256;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         have = 1'b0; exp_err = 1'b0; next_free = 0;
      end else if (!cmd_sel_n && cmd_row_n && !cmd_col_n && cmd_wr_n) begin
         if (have && cyc < next_free) exp_err = 1'b1;
         else begin
            have  = 1'b1;
            t0    = cyc;
            m_rl  = clampi(int'(cfg_cl), 3, 6) + clampi(int'(cfg_al), 0, 4);
            m_n   = cfg_bl8 ? 8 : 4;
            m_col = int'(cmd_addr);
            next_free = cyc + m_rl + m_n / 2;
            lcl = int'(cfg_cl); lal = int'(cfg_al); lbl = int'(cfg_bl8);
            legal = (cfg_cl >= 3'd3 && cfg_cl <= 3'd6 && cfg_al <= 3'd4);
         end
      end
   end

   always @(posedge clk) begin
      #5;
      if (!rst_n) begin
         chk(!dqs_oe && !dqs_hi && !dq_valid && !rd_err && dq_rise == '0 && dq_fall == '0,
             "R10", {dqs_oe, dqs_hi, dq_valid, rd_err}, 0);
      end else begin
         mm  = cyc - t0;
         pre = have && (mm == m_rl - 1);
         dat = have && (mm >= m_rl) && (mm < m_rl + m_n / 2);
         moved = (int'(cfg_cl) != lcl) || (int'(cfg_al) != lal) || (int'(cfg_bl8) != lbl);
         tg = pre ? "R4" : (dat ? "R5" : "R7");
         chk(dqs_oe == (pre || dat), tg, int'(dqs_oe), int'(pre || dat));
         chk(dqs_hi == dat, tg, int'(dqs_hi), int'(dat));
         if (dat) tg = moved ? "R9" : (legal ? "R2" : "R3");
         chk(dq_valid == dat, tg, int'(dq_valid), int'(dat));
         er = '0; ef = '0;
         if (dat) begin
            kk = mm - m_rl;
            er = shadow[beat_addr(m_col, m_n, 2 * kk)];
            ef = shadow[beat_addr(m_col, m_n, 2 * kk + 1)];
         end
         tg = dat ? "R6 R11" : "R7";
         chk(dq_rise == er, tg, int'(dq_rise), int'(er));
         chk(dq_fall == ef, tg, int'(dq_fall), int'(ef));
         chk(rd_err == exp_err, "R8", int'(rd_err), int'(exp_err));
      end
   end

   task automatic send(input logic s, input logic r, input logic c, input logic w, input int col);
      @(negedge clk);
      cmd_sel_n = s; cmd_row_n = r; cmd_col_n = c; cmd_wr_n = w;
      cmd_addr = COL_W'(col);
      @(negedge clk);
      cmd_sel_n = 1'b1; cmd_row_n = 1'b1; cmd_col_n = 1'b1; cmd_wr_n = 1'b1;
   endtask

   task automatic load(input int a, input int d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = COL_W'(a); ld_data = DQ_W'(d);
      shadow[a] = DQ_W'(d);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!rd_err && !dqs_oe && !dq_valid, "R10", int'(rd_err), 0);
      rst_n = 1'b1;
   endtask

   task automatic set_cfg(input int cl, input int al, input int bl);
      cfg_cl = CFG_W'(cl); cfg_al = CFG_W'(al); cfg_bl8 = bl[0];
   endtask

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      chk(!dqs_oe && !dq_valid && !rd_err && dq_rise == '0, "R10", int'(dqs_oe), 0);
      rst_n = 1'b1;

      // R11: preload every word
      for (int a = 0; a < DEPTH; a++) load(a, pat(a));

      // R2 R3 R5 R6 R9: every latency setting, both burst lengths, rotating columns
      idx = 0;
      for (int cl = 0; cl < 8; cl++)
         for (int al = 0; al < 8; al++)
            for (int bl = 0; bl < 2; bl++) begin
               set_cfg(cl, al, bl);
               send(1'b0, 1'b1, 1'b0, 1'b1, (idx * 5 + 3) % DEPTH);
               if (idx % 2 == 1) set_cfg((cl + 3) % 8, (al + 5) % 8, 1 - bl);  // R9
               repeat (14) @(negedge clk);
               idx++;
            end

      // R1: every non-read command pattern starts nothing
      set_cfg(3, 0, 0);
      for (int c = 0; c < 16; c++) begin
         if (c != 5) begin
            send(c[3], c[2], c[1], c[0], 0);
            for (int w = 0; w < 8; w++) begin
               @(negedge clk);
               chk(!dqs_oe && !dq_valid, "R1", int'(dqs_oe), 0);
            end
         end
      end

      // R11: overwrite a word, then read it back in an 8-beat burst
      load(9, 8'hC3);
      set_cfg(4, 1, 1);
      send(1'b0, 1'b1, 1'b0, 1'b1, 9);
      repeat (14) @(negedge clk);

      // R8: read at exactly the free edge is accepted (RL=3, 2 clocks)
      set_cfg(3, 0, 0);
      send(1'b0, 1'b1, 1'b0, 1'b1, 6);
      repeat (3) @(negedge clk);
      send(1'b0, 1'b1, 1'b0, 1'b1, 13);
      repeat (10) @(negedge clk);
      chk(rd_err == 1'b0, "R8", int'(rd_err), 0);

      // R8: read one edge early is ignored and flags an error
      send(1'b0, 1'b1, 1'b0, 1'b1, 2);
      repeat (2) @(negedge clk);
      send(1'b0, 1'b1, 1'b0, 1'b1, 11);
      repeat (10) @(negedge clk);
      chk(rd_err == 1'b1, "R8", int'(rd_err), 1);
      repeat (5) @(negedge clk);
      chk(rd_err == 1'b1, "R8", int'(rd_err), 1);
      do_reset();

      // R8: read during the wait before data is ignored
      set_cfg(6, 4, 1);
      send(1'b0, 1'b1, 1'b0, 1'b1, 15);
      send(1'b0, 1'b1, 1'b0, 1'b1, 4);
      repeat (16) @(negedge clk);
      chk(rd_err == 1'b1, "R8", int'(rd_err), 1);

      // R10: reset clears the flag
      do_reset();
      @(negedge clk);
      chk(rd_err == 1'b0, "R10", int'(rd_err), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule